// File: doc/BRIEF.md
# SATA Host Port Register Window

This block is the software-visible register set of a single SATA host adapter port. A host reaches it through a 32-word (128-byte) window. Each access carries a word index and moves a full 32-bit word. The window holds the command-list and received-frame base addresses, the interrupt status and enable words, the command/status word, the task-file and signature words, the four serial-link registers (status, control, error and active), and the command-issue word.

Every register follows its own access rule. Some are plain read/write. Some clear the bits written as 1, and some set them. Some keep fields that only hardware may change. Some ignore writes altogether.

The block gives the global interrupt logic a masked interrupt request for the port. It raises a one-cycle reset request when software releases the link-reset code in the control register. It builds the link-status word from a device-present input. It clears the issue bit of the busy command slot when the command engine reports completion. Fetching command lists, the frame engines and data movement live elsewhere. They reach this block through event and status inputs.

Top module: `sata_port_regs`

## Requirements
- R1: After reset every register reads 0, `irq_req`, `port_reset_req` and `rvalid` are 0, and `ci_word` is 0. This assumes the hardware status inputs are held at 0.
- R2: A read with `rd_en` high returns the word at `addr` on `rdata`, with `rvalid` high, in the cycle after the request. Words 0..3 (list base low/high, frame base low/high) and word 11 (link control) store the full written word.
- R3: A write to word 5 (interrupt enable) stores `wdata & 32'hFDC000FF`.
- R4: Word 4 (interrupt status) sets every bit that is high on `is_evt`, and clears the bits written as 1. When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: `irq_req` is high exactly when (interrupt status & interrupt enable) is nonzero. It reflects a change one cycle after the event or write that causes it.
- R6: Word 6 (command/status) has hardware-owned fields that writes cannot change. Bit 15 follows `list_run`, bit 14 follows `fis_run`, and bits 13:8 follow `ccs_in`; all three are sampled every cycle. Bits 31:28 always read 0. All other bits take their value from the last write. `cmd_word` shows the current value.
- R7: Take a write to word 11 in which the stored bits 3:0 equal 1 and the written bits 3:0 equal 0. Such a write makes `port_reset_req` high for exactly the one cycle after the write. No other write to word 11 raises `port_reset_req`. The written value is stored in every case.
- R8: Word 12 (link error) sets bits from `serr_evt` and clears bits written as 1. Word 13 (link active) sets the bits written as 1. Word 14 (command issue) sets the bits written as 1, and `ci_word` shows the current value.
- R9: Word 8 (task file) loads `tfd_val` when `tfd_ld` is high. Word 9 (signature) loads `sig_val` when `sig_ld` is high. Writes from the host to words 8, 9 and 10 have no effect.
- R10: Word 10 (link status) reads 32'h00000113 while `dev_present` is high and 0 while it is low. That value encodes detect=3 in bits 3:0, speed=1 in bits 7:4 and power state=1 in bits 11:8.
- R11: `busy_set` with `busy_idx` marks that slot busy. `cmd_done` clears the issue bit of the busy slot and leaves no slot busy. A `cmd_done` with no slot busy changes nothing. A host write that sets the same issue bit in the same cycle as the completion wins, and the bit stays set.
- R12: Word 7, words 15..31 and any other word not named above read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 5 | Word index within the window |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| dev_present | input | 1 | A device is attached and its link is up |
| is_evt | input | 32 | Interrupt status set events |
| serr_evt | input | 32 | Link error set events |
| tfd_ld | input | 1 | Load strobe for the task-file word |
| tfd_val | input | 32 | Task-file value from the device |
| sig_ld | input | 1 | Load strobe for the signature word |
| sig_val | input | 32 | Device signature |
| list_run | input | 1 | Command-list engine running |
| fis_run | input | 1 | Frame-receive engine running |
| ccs_in | input | 6 | Current command slot from the engine |
| busy_set | input | 1 | Mark `busy_idx` as the busy slot |
| busy_idx | input | 5 | Slot that became busy |
| cmd_done | input | 1 | The busy command completed |
| irq_req | output | 1 | Masked port interrupt request |
| port_reset_req | output | 1 | One-cycle port reset request |
| cmd_word | output | 32 | Current command/status word |
| ci_word | output | 32 | Current command-issue word |

## Verification
The assertions assume the host never raises `rd_en` and `wr_en` in the same cycle. They also assume `busy_set` and `cmd_done` never arrive together, so a completion always refers to a slot marked in an earlier cycle. The stimulus drives every host access as a single strobe and leaves at least one idle cycle between accesses. It pulses the busy and completion strobes in separate cycles. It keeps the engine status inputs steady across each command-word check, so the hardware-owned fields have one expected value.

// File: rtl/sata_port_pkg.sv
package sata_port_pkg;

    localparam int WORD_W = 32;

    // Word indices inside the port window; the index order is decoded by software.
    localparam int W_CLB   = 0;
    localparam int W_CLBU  = 1;
    localparam int W_FB    = 2;
    localparam int W_FBU   = 3;
    localparam int W_IS    = 4;
    localparam int W_IE    = 5;
    localparam int W_CMD   = 6;
    localparam int W_TFD   = 8;
    localparam int W_SIG   = 9;
    localparam int W_SSTS  = 10;
    localparam int W_SCTL  = 11;
    localparam int W_SERR  = 12;
    localparam int W_SACT  = 13;
    localparam int W_CI    = 14;

    localparam logic [WORD_W-1:0] IE_KEEP   = 32'hFDC0_00FF;
    localparam logic [WORD_W-1:0] CMD_HWOWN = 32'h0000_FF00;
    localparam logic [WORD_W-1:0] CMD_ZERO  = 32'hF000_0000;

    localparam logic [3:0] DET_ACTIVE = 4'h1;
    localparam logic [3:0] DET_IDLE   = 4'h0;

    typedef struct packed {
        logic [WORD_W-1:0] clb;
        logic [WORD_W-1:0] clbu;
        logic [WORD_W-1:0] fb;
        logic [WORD_W-1:0] fbu;
        logic [WORD_W-1:0] is_w;
        logic [WORD_W-1:0] ie;
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] tfd;
        logic [WORD_W-1:0] sig;
        logic [WORD_W-1:0] sctl;
        logic [WORD_W-1:0] serr;
    } port_words_t;

endpackage

// File: rtl/sata_port_decode.sv
module sata_port_decode #(
    parameter int AW = 5,
    localparam int NW = 1 << AW
) (
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    output logic [NW-1:0] wsel
);
    for (genvar i = 0; i < NW; i++) begin : g_sel
        assign wsel[i] = wr_en && (addr == AW'(i));
    end
endmodule

// File: rtl/sata_port_sstatus.sv
module sata_port_sstatus #(
    parameter logic [3:0] DET_UP = 4'h3,
    parameter logic [3:0] SPD    = 4'h1,
    parameter logic [3:0] IPM    = 4'h1
) (
    input  logic        dev_present,
    output logic [31:0] ssts
);
    always_comb begin
        if (dev_present) ssts = {20'h0, IPM, SPD, DET_UP};
        else             ssts = 32'h0;
    end
endmodule

// File: rtl/sata_port_rdmux.sv
module sata_port_rdmux #(
    parameter int AW = 5,
    localparam int NW = 1 << AW
) (
    input  logic [AW-1:0]       addr,
    input  logic [NW-1:0][31:0] words,
    output logic [31:0]         data
);
    assign data = words[addr];
endmodule

// File: rtl/sata_port_regs.sv
module sata_port_regs
    import sata_port_pkg::*;
#(
    parameter int AW        = 5,
    parameter int NUM_SLOTS = 32,
    localparam int NW = 1 << AW,
    localparam int SW = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid,
    input  logic              dev_present,
    input  logic [WORD_W-1:0] is_evt,
    input  logic [WORD_W-1:0] serr_evt,
    input  logic              tfd_ld,
    input  logic [WORD_W-1:0] tfd_val,
    input  logic              sig_ld,
    input  logic [WORD_W-1:0] sig_val,
    input  logic              list_run,
    input  logic              fis_run,
    input  logic [5:0]        ccs_in,
    input  logic              busy_set,
    input  logic [SW-1:0]     busy_idx,
    input  logic              cmd_done,
    output logic              irq_req,
    output logic              port_reset_req,
    output logic [WORD_W-1:0] cmd_word,
    output logic [WORD_W-1:0] ci_word
);

    typedef struct packed {
        port_words_t          w;
        logic [NUM_SLOTS-1:0] sact;
        logic [NUM_SLOTS-1:0] ci;
        logic                 busy_vld;
        logic [SW-1:0]        busy_slot;
        logic                 rst_pulse;
        logic [WORD_W-1:0]    rdata;
        logic                 rvalid;
    } state_t;

    state_t s_d, s_q;

    logic [NW-1:0]             wsel;
    logic [WORD_W-1:0]         ssts_val;
    logic [NW-1:0][WORD_W-1:0] rd_words;
    logic [WORD_W-1:0]         rd_sel;
    logic [WORD_W-1:0]         hw_cmd_bits;

    sata_port_decode #(.AW(AW)) u_decode (
        .wr_en (wr_en),
        .addr  (addr),
        .wsel  (wsel)
    );

    sata_port_sstatus u_sstatus (
        .dev_present (dev_present),
        .ssts        (ssts_val)
    );

    always_comb begin
        for (int i = 0; i < NW; i++) rd_words[i] = '0;
        rd_words[W_CLB]  = s_q.w.clb;
        rd_words[W_CLBU] = s_q.w.clbu;
        rd_words[W_FB]   = s_q.w.fb;
        rd_words[W_FBU]  = s_q.w.fbu;
        rd_words[W_IS]   = s_q.w.is_w;
        rd_words[W_IE]   = s_q.w.ie;
        rd_words[W_CMD]  = s_q.w.cmd;
        rd_words[W_TFD]  = s_q.w.tfd;
        rd_words[W_SIG]  = s_q.w.sig;
        rd_words[W_SSTS] = ssts_val;
        rd_words[W_SCTL] = s_q.w.sctl;
        rd_words[W_SERR] = s_q.w.serr;
        rd_words[W_SACT] = WORD_W'(s_q.sact);
        rd_words[W_CI]   = WORD_W'(s_q.ci);
    end

    sata_port_rdmux #(.AW(AW)) u_rdmux (
        .addr  (addr),
        .words (rd_words),
        .data  (rd_sel)
    );

    assign hw_cmd_bits = {16'h0, list_run, fis_run, ccs_in, 8'h0};

    always_comb begin
        s_d = s_q;

        if (wsel[W_CLB])  s_d.w.clb  = wdata;
        if (wsel[W_CLBU]) s_d.w.clbu = wdata;
        if (wsel[W_FB])   s_d.w.fb   = wdata;
        if (wsel[W_FBU])  s_d.w.fbu  = wdata;
        if (wsel[W_IE])   s_d.w.ie   = wdata & IE_KEEP;
        if (wsel[W_SCTL]) s_d.w.sctl = wdata;

        // Interrupt status: clear on write-1, hardware events win.
        s_d.w.is_w = (s_q.w.is_w & ~(wsel[W_IS] ? wdata : '0)) | is_evt;
        s_d.w.serr = (s_q.w.serr & ~(wsel[W_SERR] ? wdata : '0)) | serr_evt;

        // Command word: hardware-owned fields mirror the engine every cycle.
        if (wsel[W_CMD]) s_d.w.cmd = wdata & ~(CMD_HWOWN | CMD_ZERO);
        else             s_d.w.cmd = s_q.w.cmd & ~(CMD_HWOWN | CMD_ZERO);
        s_d.w.cmd = s_d.w.cmd | hw_cmd_bits;

        if (tfd_ld) s_d.w.tfd = tfd_val;
        if (sig_ld) s_d.w.sig = sig_val;

        if (wsel[W_SACT]) s_d.sact = s_q.sact | wdata[NUM_SLOTS-1:0];

        // Completion first, then host write-1-to-set, so a new issue wins.
        if (cmd_done && s_q.busy_vld) begin
            s_d.ci[s_q.busy_slot] = 1'b0;
            s_d.busy_vld          = 1'b0;
        end
        if (wsel[W_CI]) s_d.ci = s_d.ci | wdata[NUM_SLOTS-1:0];

        if (busy_set) begin
            s_d.busy_vld  = 1'b1;
            s_d.busy_slot = busy_idx;
        end

        s_d.rst_pulse = wsel[W_SCTL] && (s_q.w.sctl[3:0] == DET_ACTIVE)
                        && (wdata[3:0] == DET_IDLE);

        s_d.rvalid = rd_en;
        s_d.rdata  = rd_en ? rd_sel : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata          = s_q.rdata;
    assign rvalid         = s_q.rvalid;
    assign irq_req        = |(s_q.w.is_w & s_q.w.ie);
    assign port_reset_req = s_q.rst_pulse;
    assign cmd_word       = s_q.w.cmd;
    assign ci_word        = WORD_W'(s_q.ci);

    // R2: read data appears exactly one cycle after the request
    assert_rvalid_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid == $past(rd_en));

    // R3: enable word keeps only the implemented bits of the write
    assert_ie_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(W_IE)) |=> ((s_q.w.ie & ~IE_KEEP) == '0));

    // R5: a request needs at least one enabled bit
    assert_irq_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (s_q.w.ie != '0));

    // R6: after a host write, the zero field is clear and hardware fields follow the engine
    assert_cmd_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(W_CMD)) |=>
        (cmd_word[31:28] == 4'h0 && cmd_word[15] == $past(list_run)
         && cmd_word[13:8] == $past(ccs_in)));

    // R7: reset request only after the active-to-idle control write
    assert_reset_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        port_reset_req |-> $past(wr_en && addr == AW'(W_SCTL) && wdata[3:0] == 4'h0));

    // R10: link-status read follows device presence
    assert_ssts_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(W_SSTS)) |=>
        (rdata == ($past(dev_present) ? 32'h113 : 32'h0)));

    // R11: completion without a same-cycle reissue drops the busy slot's bit
    assert_done_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && s_q.busy_vld && !busy_set && !(wr_en && addr == AW'(W_CI)))
        |=> !ci_word[$past(s_q.busy_slot)]);

endmodule

// File: tb/sata_port_regs_bench.sv
module sata_port_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic        dev_present = 1'b0;
    logic [31:0] is_evt = '0, serr_evt = '0;
    logic        tfd_ld = 1'b0, sig_ld = 1'b0;
    logic [31:0] tfd_val = '0, sig_val = '0;
    logic        list_run = 1'b0, fis_run = 1'b0;
    logic [5:0]  ccs_in = '0;
    logic        busy_set = 1'b0, cmd_done = 1'b0;
    logic [4:0]  busy_idx = '0;
    logic        irq_req, port_reset_req;
    logic [31:0] cmd_word, ci_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    sata_port_regs u_sata_port_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .dev_present(dev_present),
        .is_evt(is_evt), .serr_evt(serr_evt), .tfd_ld(tfd_ld), .tfd_val(tfd_val),
        .sig_ld(sig_ld), .sig_val(sig_val), .list_run(list_run), .fis_run(fis_run),
        .ccs_in(ccs_in), .busy_set(busy_set), .busy_idx(busy_idx),
        .cmd_done(cmd_done), .irq_req(irq_req), .port_reset_req(port_reset_req),
        .cmd_word(cmd_word), .ci_word(ci_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop expected read data as the design returns it.
    always @(negedge clk) begin
        cycles++;
        if (rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2 unexpected read data actual=%h expected=none", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
        if (cycles > WATCHDOG) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b1; addr = 5'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq_req", {31'h0, irq_req}, 32'h0);
        check("R1 port_reset_req", {31'h0, port_reset_req}, 32'h0);
        check("R1 ci_word", ci_word, 32'h0);
        for (int i = 0; i < 32; i++) rd(i, 32'h0, $sformatf("R1 word %0d", i));

        // R2: plain read/write words
        wr(0, 32'hDEAD_BE00); wr(1, 32'h0000_0012); wr(2, 32'hCAFE_F000); wr(3, 32'h3);
        rd(0, 32'hDEAD_BE00, "R2 list base low");
        rd(1, 32'h0000_0012, "R2 list base high");
        rd(2, 32'hCAFE_F000, "R2 frame base low");
        rd(3, 32'h3, "R2 frame base high");

        // R3: enable mask
        wr(5, 32'hFFFF_FFFF);
        rd(5, 32'hFDC0_00FF, "R3 enable mask");

        // R4/R5: status events, clearing, interrupt request
        @(negedge clk); is_evt = 32'h5; @(negedge clk); is_evt = '0;
        rd(4, 32'h5, "R4 status set by events");
        check("R5 irq high", {31'h0, irq_req}, 32'h1);
        wr(4, 32'h1);
        rd(4, 32'h4, "R4 write-1 clears");
        check("R5 irq still high", {31'h0, irq_req}, 32'h1);
        wr(5, 32'h0);
        check("R5 irq low after enable cleared", {31'h0, irq_req}, 32'h0);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'd4; wdata = 32'h8; is_evt = 32'h8;
        @(negedge clk);
        wr_en = 1'b0; is_evt = '0;
        rd(4, 32'hC, "R4 event wins over clear");

        // R6: command word
        @(negedge clk); list_run = 1'b1; fis_run = 1'b0; ccs_in = 6'h15;
        wr(6, 32'hFFFF_FFFF);
        check("R6 cmd after all-ones", cmd_word, 32'h0FFF_95FF);
        rd(6, 32'h0FFF_95FF, "R6 cmd read");
        wr(6, 32'h0);
        check("R6 cmd after zero", cmd_word, 32'h0000_9500);

        // R7: control word and reset request
        wr(11, 32'h1);
        check("R7 no reset on 0->1", {31'h0, port_reset_req}, 32'h0);
        wr(11, 32'h0000_0300);
        check("R7 reset on 1->0", {31'h0, port_reset_req}, 32'h1);
        @(negedge clk);
        check("R7 reset pulse one cycle", {31'h0, port_reset_req}, 32'h0);
        wr(11, 32'h2); wr(11, 32'h0);
        check("R7 no reset on 2->0", {31'h0, port_reset_req}, 32'h0);
        rd(11, 32'h0, "R7 value stored");

        // R8: error, active, issue
        @(negedge clk); serr_evt = 32'hF0; @(negedge clk); serr_evt = '0;
        wr(12, 32'h30);
        rd(12, 32'hC0, "R8 error write-1 clears");
        wr(13, 32'h1); wr(13, 32'h4);
        rd(13, 32'h5, "R8 active write-1 sets");
        wr(14, 32'h3); wr(14, 32'h10);
        check("R8 issue write-1 sets", ci_word, 32'h13);

        // R9/R10: read-only words
        @(negedge clk); tfd_ld = 1'b1; tfd_val = 32'h50; sig_ld = 1'b1; sig_val = 32'h0101;
        @(negedge clk); tfd_ld = 1'b0; sig_ld = 1'b0;
        wr(8, 32'hFFFF); wr(9, 32'hFFFF);
        rd(8, 32'h50, "R9 task file ignores write");
        rd(9, 32'h0101, "R9 signature ignores write");
        @(negedge clk); dev_present = 1'b1;
        wr(10, 32'hFFFF_FFFF);
        rd(10, 32'h113, "R10 link status device present");
        @(negedge clk); dev_present = 1'b0;
        rd(10, 32'h0, "R10 link status no device");

        // R11: completion
        @(negedge clk); busy_set = 1'b1; busy_idx = 5'd4;
        @(negedge clk); busy_set = 1'b0;
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0;
        check("R11 done clears busy bit", ci_word, 32'h03);
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0;
        check("R11 done with no busy slot", ci_word, 32'h03);
        @(negedge clk); busy_set = 1'b1; busy_idx = 5'd0;
        @(negedge clk); busy_set = 1'b0;
        @(negedge clk); cmd_done = 1'b1; wr_en = 1'b1; addr = 5'd14; wdata = 32'h1;
        @(negedge clk); cmd_done = 1'b0; wr_en = 1'b0;
        check("R11 reissue wins over completion", ci_word, 32'h03);
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0;
        check("R11 busy slot gone after completion", ci_word, 32'h03);

        // R12: reserved and unimplemented words
        wr(7, 32'hFFFF_FFFF); wr(15, 32'hFFFF_FFFF); wr(17, 32'hFFFF_FFFF);
        wr(20, 32'hFFFF_FFFF); wr(31, 32'hFFFF_FFFF);
        rd(7, 32'h0, "R12 reserved word 7");
        rd(15, 32'h0, "R12 word 15");
        rd(17, 32'h0, "R12 word 17");
        rd(31, 32'h0, "R12 word 31");
        rd(0, 32'hDEAD_BE00, "R12 list base untouched");
        rd(5, 32'h0, "R12 enable untouched");
        check("R12 issue untouched", ci_word, 32'h03);

        repeat (4) @(negedge clk);
        check("R2 all reads returned", 32'(exp_q.size()), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule